// File: doc/BRIEF.md
# DSP Address Generation Unit

This block drives the address side of one data memory port in a signal-processing datapath. It holds a single address register and presents that register on its output every cycle. When the access strobe is high, the register is modified after the access, so the current address is used first and the next cycle shows the stepped value. The step can go up or down, and the update rule is chosen from three modes:
- plain linear arithmetic;
- a circular-buffer mode, which keeps a delay line inside a fixed window so that new samples overwrite the oldest slot without moving any data;
- a reverse-carry mode, which walks a buffer in the scrambled order used by a radix-2 FFT.

Configuration inputs give the mode, the direction, the buffer base, the buffer length (or FFT size) and the step. A load input writes a start address into the register.

Top module: `dsp_agu`

## Requirements
- R1: A clock edge with `rst` high sets `addr_o` to 0.
- R2: A clock edge with `load_i` high (and `rst` low) sets `addr_o` to `load_addr_i`, whatever `strobe_i` is.
- R3: A clock edge with `rst`, `load_i` and `strobe_i` all low leaves `addr_o` unchanged, whatever the configuration inputs are.
- R4: Mode code 0 (linear), and also code 3, adds `step_i` to the register when `dec_i` is 0 and subtracts it when `dec_i` is 1. The result wraps modulo 2^32 only, with no buffer window.
- R5: Mode code 1 (modulo) with `dec_i`=0 sets the offset from `base_i` to (offset + `step_i`) mod `len_i`.
- R6: Mode code 1 with `dec_i`=1 sets the offset from `base_i` to (offset − `step_i`) mod `len_i`, wrapping below the base to the top of the buffer.
- R7: In modulo mode, for any `len_i` from 1 to 65536 with 0 ≤ `step_i` ≤ `len_i` and the register inside the window, the new address always lies in the range `base_i` to `base_i`+`len_i`−1.
- R8: Mode code 2 (bit-reversed) with `dec_i`=0 adds `len_i`/2 to the low 16 bits of the offset from `base_i`, with the carry running from the MSB toward the LSB. Starting at `base_i`, an N-point buffer (N a power of two up to 65536) is visited as `base_i` + bitreverse_log2(N)(k) for k = 0, 1, 2, ...
- R9: Mode code 2 with `dec_i`=1 does the reverse-borrow subtraction, so it visits the same order backwards.
- R10: Post-modify: in the cycle in which `strobe_i` is high, `addr_o` still shows the address before the update. The stepped value appears only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Update mode: 0 linear, 1 modulo, 2 bit-reversed, 3 linear |
| dec_i | input | 1 | 0 = post-increment, 1 = post-decrement |
| base_i | input | 32 | Buffer base address (modulo and bit-reversed modes) |
| len_i | input | 17 | Buffer length (modulo) or FFT size (bit-reversed) |
| step_i | input | 32 | Step size (linear and modulo modes) |
| load_i | input | 1 | Write `load_addr_i` into the address register |
| load_addr_i | input | 32 | Start address to load |
| strobe_i | input | 1 | Access strobe; advances the register after the access |
| addr_o | output | 32 | Current address (the register) |

## Verification
Linear stepping is tried with a step of 8, with a decrement, and across the 2^32 boundary, which separates a plain adder from one that wraps. Circular mode is tried with a step of 2 that does not divide a length of 5, so each offset position is reached only by correct wrapping. It is also tried with length 1 and with a step equal to a full 65536 buffer, which exposes off-by-one errors in the compare and subtract. Reverse-carry mode is walked over 8 and 65536 points in both directions. A wrong carry direction, or a wrong half-size, breaks the scrambled order. Idle cycles, configuration changes without a strobe, and a load together with a strobe show that the register changes only when it should.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_LINEAR  = 2'd0,
    AGU_MODULO  = 2'd1,
    AGU_BITREV  = 2'd2,
    AGU_LINEAR2 = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_linear_step.sv
module agu_linear_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] nxt_o
);
  always_comb begin
    if (dec_i) nxt_o = cur_i - step_i;
    else       nxt_o = cur_i + step_i;
  end
endmodule

// File: rtl/agu_modulo_step.sv
module agu_modulo_step #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] off, len_x, res;
  logic              over;

  assign off   = cur_i - base_i;
  assign len_x = {{PAD_W{1'b0}}, len_i};
  // one-bit-wider sum so the compare sees any carry out
  assign over  = ({1'b0, off} + {1'b0, step_i}) >= {1'b0, len_x};

  always_comb begin
    if (dec_i) begin
      if (off >= step_i) res = off - step_i;
      else               res = off + len_x - step_i;
    end else begin
      if (over) res = off + step_i - len_x;
      else      res = off + step_i;
    end
  end

  assign nxt_o = base_i + res;
endmodule

// File: rtl/agu_bitrev_step.sv
module agu_bitrev_step #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  half_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] off;
  logic [OFS_W-1:0]  off_r, half_r, sum_r, sum_n;

  assign off = cur_i - base_i;

  // mirror the low offset bits so an ordinary adder carries toward the LSB
  for (genvar i = 0; i < OFS_W; i++) begin : g_mirror
    assign off_r[i]  = off[OFS_W-1-i];
    assign half_r[i] = half_i[OFS_W-1-i];
    assign sum_n[i]  = sum_r[OFS_W-1-i];
  end

  assign sum_r = dec_i ? (off_r - half_r) : (off_r + half_r);
  assign nxt_o = base_i + {off[ADDR_W-1:OFS_W], sum_n};
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  localparam int LEN_W = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              dec_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              strobe_i,
  output logic [ADDR_W-1:0] addr_o
);
  import agu_pkg::*;

  logic [ADDR_W-1:0] addr_q, nxt_lin, nxt_mod, nxt_brv, nxt;

  agu_linear_step #(.ADDR_W(ADDR_W)) u_lin (
    .cur_i(addr_q), .step_i(step_i), .dec_i(dec_i), .nxt_o(nxt_lin)
  );

  agu_modulo_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mod (
    .cur_i(addr_q), .base_i(base_i), .len_i(len_i), .step_i(step_i),
    .dec_i(dec_i), .nxt_o(nxt_mod)
  );

  agu_bitrev_step #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_brv (
    .cur_i(addr_q), .base_i(base_i), .half_i(len_i[LEN_W-1:1]),
    .dec_i(dec_i), .nxt_o(nxt_brv)
  );

  always_comb begin
    case (mode_i)
      AGU_MODULO: nxt = nxt_mod;
      AGU_BITREV: nxt = nxt_brv;
      default:    nxt = nxt_lin;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           addr_q <= '0;
    else if (load_i)   addr_q <= load_addr_i;
    else if (strobe_i) addr_q <= nxt;
  end

  assign addr_o = addr_q;

  // R1
  p_reset_r1: assert property (@(posedge clk) rst |=> addr_o == '0);

  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(load_addr_i));

  // R3
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !strobe_i) |=> $stable(addr_o));

  // R4
  p_lin_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !load_i && !dec_i && (mode_i == AGU_LINEAR || mode_i == AGU_LINEAR2))
    |=> addr_o == $past(addr_o) + $past(step_i));

  // R7
  p_mod_range_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !load_i && mode_i == AGU_MODULO && len_i != '0 &&
     {1'b0, step_i} <= {{(ADDR_W-LEN_W+1){1'b0}}, len_i} &&
     (addr_o - base_i) < {{(ADDR_W-LEN_W){1'b0}}, len_i})
    |=> (addr_o - $past(base_i)) < {{(ADDR_W-LEN_W){1'b0}}, $past(len_i)});
endmodule

// File: tb/tb_dsp_agu.sv
module tb_dsp_agu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        dec = 1'b0;
  logic [31:0] base = '0;
  logic [16:0] len = 17'd1;
  logic [31:0] step = '0;
  logic        load = 1'b0;
  logic [31:0] load_addr = '0;
  logic        strobe = 1'b0;
  logic [31:0] addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic [31:0] m_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_agu dut (
    .clk(clk), .rst(rst), .mode_i(mode), .dec_i(dec), .base_i(base),
    .len_i(len), .step_i(step), .load_i(load), .load_addr_i(load_addr),
    .strobe_i(strobe), .addr_o(addr_o)
  );

  function automatic logic [31:0] revn(input logic [31:0] v, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  function automatic int log2n(input int v);
    int n = 0;
    while ((1 << n) < v) n++;
    return n;
  endfunction

  function automatic logic [31:0] model_next(input logic [31:0] a);
    longint off, l, s;
    int n;
    logic [31:0] k;
    off = longint'(a - base);
    l = longint'(len);
    s = longint'(step);
    case (mode)
      2'd1: begin
        if (!dec) off = (off + s) % l;
        else      off = (off + l - (s % l)) % l;
        return base + 32'(off);
      end
      2'd2: begin
        n = log2n(int'(len));
        k = revn(32'(off), n);
        if (!dec) k = k + 32'd1; else k = k - 32'd1;
        if (n < 32) k = k & ((32'd1 << n) - 32'd1);
        return base + revn(k, n);
      end
      default: return dec ? a - step : a + step;
    endcase
  endfunction

  // monitor: pops one expectation after each edge
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_tests++;
      if (addr_o !== e) begin
        n_fail++;
        $display("FAIL %s: addr_o=%h expected %h", t, addr_o, e);
      end
    end
  end

  task automatic cyc(input bit r, input bit ld, input bit stb,
                     input logic [31:0] la, input string tag);
    logic [31:0] old;
    @(negedge clk);
    rst = r; load = ld; strobe = stb; load_addr = la;
    old = m_addr;
    if (r)        m_addr = '0;
    else if (ld)  m_addr = la;
    else if (stb) m_addr = model_next(m_addr);
    q_exp.push_back(m_addr);
    q_tag.push_back(tag);
    #1;
    if (stb && !ld && !r) begin  // R10: pre-update address still shown
      n_tests++;
      if (addr_o !== old) begin
        n_fail++;
        $display("FAIL R10: addr_o=%h expected %h", addr_o, old);
      end
    end
  endtask

  task automatic setcfg(input logic [1:0] md, input bit d, input logic [31:0] b,
                        input logic [16:0] l, input logic [31:0] s);
    @(negedge clk);
    mode = md; dec = d; base = b; len = l; step = s;
    rst = 1'b0; load = 1'b0; strobe = 1'b0;
    q_exp.push_back(m_addr);
    q_tag.push_back("R3 cfg change without strobe");
  endtask

  task automatic steps(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) cyc(1'b0, 1'b0, 1'b1, '0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(1'b1, 1'b0, 1'b0, '0, "R1 reset");
    cyc(1'b1, 1'b0, 1'b1, '0, "R1 reset with strobe");
    // linear mode
    setcfg(2'd0, 1'b0, '0, 17'd1, 32'd8);
    cyc(1'b0, 1'b1, 1'b0, 32'h100, "R2 load");
    steps(3, "R4 linear +8");
    cyc(1'b0, 1'b0, 1'b0, '0, "R3 idle hold");
    cyc(1'b0, 1'b0, 1'b0, '0, "R3 idle hold");
    setcfg(2'd0, 1'b1, '0, 17'd1, 32'd3);
    steps(2, "R4 linear -3");
    setcfg(2'd0, 1'b0, 32'h5000, 17'd4, 32'd8);
    cyc(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, "R2 load near top");
    steps(2, "R4 linear wraps at 2^32 only");
    setcfg(2'd3, 1'b0, '0, 17'd1, 32'd5);
    steps(2, "R4 mode 3 linear");
    cyc(1'b0, 1'b1, 1'b1, 32'hABCD_0000, "R2 load beats strobe");
    // modulo
    setcfg(2'd1, 1'b0, 32'h1000, 17'd5, 32'd2);
    cyc(1'b0, 1'b1, 1'b0, 32'h1000, "R2 load base");
    steps(6, "R5 modulo +2 len 5");
    setcfg(2'd1, 1'b1, 32'h1000, 17'd5, 32'd3);
    steps(6, "R6 modulo -3 len 5");
    setcfg(2'd1, 1'b0, 32'h2000, 17'd1, 32'd1);
    cyc(1'b0, 1'b1, 1'b0, 32'h2000, "R2 load");
    steps(2, "R7 modulo len 1");
    setcfg(2'd1, 1'b0, 32'h40000, 17'd65536, 32'd1);
    cyc(1'b0, 1'b1, 1'b0, 32'h4FFFF, "R2 load buffer end");
    steps(2, "R7 modulo len 65536 wrap");
    setcfg(2'd1, 1'b0, 32'h40000, 17'd65536, 32'd65536);
    steps(2, "R7 modulo step equal len");
    setcfg(2'd1, 1'b1, 32'h40000, 17'd65536, 32'd2);
    cyc(1'b0, 1'b1, 1'b0, 32'h40001, "R2 load");
    steps(2, "R6 modulo -2 below base");
    // bit-reversed
    setcfg(2'd2, 1'b0, 32'h3000, 17'd8, 32'd0);
    cyc(1'b0, 1'b1, 1'b0, 32'h3000, "R2 load");
    steps(9, "R8 bitrev 8-point");
    setcfg(2'd2, 1'b1, 32'h3000, 17'd8, 32'd0);
    steps(9, "R9 bitrev 8-point reverse");
    setcfg(2'd2, 1'b0, 32'h10000, 17'd65536, 32'd0);
    cyc(1'b0, 1'b1, 1'b0, 32'h10000, "R2 load");
    steps(5, "R8 bitrev 65536-point");
    setcfg(2'd2, 1'b1, 32'h10000, 17'd65536, 32'd0);
    steps(5, "R9 bitrev 65536-point reverse");
    cyc(1'b1, 1'b0, 1'b0, '0, "R1 reset mid-run");
    cyc(1'b0, 1'b0, 1'b0, '0, "R3 hold after reset");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule